// File: doc/BRIEF.md
# Round-Robin Transmit Queue Scheduler

This block decides which transmit queue is served next. Each queue has a small control register with an enable bit and an active bit. A queue is eligible when both bits are set. A doorbell names a queue that has new work, and an eligible idle queue then joins a rotation list. The scheduler takes queues from the head of that list. For each one it emits a transmit request that carries the queue index and a tag. The downstream engine answers with a completion on the status stream. The completion returns the tag and the number of bytes it sent. A nonzero length puts the queue back at the tail of the list. A zero length retires the queue until another doorbell arrives.

An operation table holds every outstanding request. The tag is the index of the table slot. When all slots are taken, no request is issued. A global enable input gates every request. A control stream can switch a queue's enable bit while traffic runs. The registers sit behind a register port in AXI4-Lite style.

Top module: `tq_rr_sched`

## Requirements
- R1: Each queue has a 32-bit register at byte address `index*4`. Bit 0 is the enable bit and bit 1 is the active bit. Both reset to 0. All other bits read 0. Addresses at or beyond the number of queues read 0, and writes to them are dropped. Every write and read response is OKAY (`2'b00`).
- R2: A request is issued only for a queue that has both bit 0 and bit 1 set. A doorbell to a queue without both bits set is ignored. A queue that reaches the head of the rotation while not eligible is removed from it.
- R3: A doorbell accepted at a clock edge, for an eligible queue that is neither listed nor in flight, makes that queue's request visible on the request port right after that edge. This holds when the rotation was empty, the global enable is high and a table slot is free.
- R4: Queues are served in the order they entered the rotation. With N queues continuously active, requests cycle 0, 1, …, N-1, 0, …
- R5: A completion with a nonzero length returns its queue to the tail of the rotation. A completion with a zero length leaves the queue idle.
- R6: A doorbell for a queue that is already listed or already in flight adds no second entry. It sets a re-arm flag instead. A later zero-length completion then puts the queue back in the rotation once.
- R7: The tag is the index of the lowest free table slot. With 16 slots, at most 16 requests are outstanding, and no request is presented while all slots are taken.
- R8: A completion whose tag names no occupied slot is ignored.
- R9: No request is presented while `sched_en` is low.
- R10: A control-stream beat writes `ctrl_enable` into bit 0 of the named queue's register.
- R11: The status and control streams are always ready. The doorbell stream is not ready in any cycle in which a status beat is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| sched_en | input | 1 | global scheduling enable |
| db_valid | input | 1 | doorbell valid |
| db_queue | input | 6 | doorbell queue index |
| db_ready | output | 1 | doorbell ready |
| ctrl_valid | input | 1 | queue enable control valid |
| ctrl_queue | input | 6 | queue to switch |
| ctrl_enable | input | 1 | new enable bit value |
| ctrl_ready | output | 1 | control ready (always high) |
| req_valid | output | 1 | transmit request valid |
| req_ready | input | 1 | transmit request ready |
| req_queue | output | 6 | queue to transmit from |
| req_tag | output | 8 | operation tag |
| sts_valid | input | 1 | completion valid |
| sts_ready | output | 1 | completion ready (always high) |
| sts_tag | input | 8 | completion tag |
| sts_len | input | 16 | bytes transmitted; 0 means queue empty |
| s_awaddr | input | 16 | write address |
| s_awvalid | input | 1 | write address valid |
| s_awready | output | 1 | write address ready |
| s_wdata | input | 32 | write data |
| s_wstrb | input | 4 | write byte strobes |
| s_wvalid | input | 1 | write data valid |
| s_wready | output | 1 | write data ready |
| s_bresp | output | 2 | write response |
| s_bvalid | output | 1 | write response valid |
| s_bready | input | 1 | write response ready |
| s_araddr | input | 16 | read address |
| s_arvalid | input | 1 | read address valid |
| s_arready | output | 1 | read address ready |
| s_rdata | output | 32 | read data |
| s_rresp | output | 2 | read response |
| s_rvalid | output | 1 | read data valid |
| s_rready | input | 1 | read data ready |

## Verification
The assertions assume that each completion tag is one the block handed out and has not yet been returned, or else a tag the table cannot match. They also assume that write address and write data arrive together. Under those conditions a queue is never both listed and in flight, which is what keeps the rotation free of duplicates and overflow. The stimulus only returns tags it has captured from fired requests, or deliberately out-of-range tags. It always drives the write address and write data in the same cycle.

// File: rtl/tq_pkg.sv
package tq_pkg;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_STATUS,
    SRC_DOORBELL
  } push_src_e;

  // a completed queue re-enters the rotation when it still has data or was re-armed
  function automatic logic keep_after_status(input logic eligible, input logic more_data,
                                             input logic rearmed);
    return eligible && (more_data || rearmed);
  endfunction

  // eligibility from the two register bits
  function automatic logic queue_ok(input logic en, input logic act);
    return en && act;
  endfunction
endpackage

// File: rtl/tq_ring.sv
module tq_ring #(
  parameter int W     = 6,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         nonempty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] fill;

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head     = slots[rd_ptr];
  assign nonempty = (fill != '0);
  assign full     = (fill == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      fill <= fill + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_data;
  end

  p_ring_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop));
  p_ring_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    pop |-> nonempty);
endmodule

// File: rtl/tq_op_table.sv
module tq_op_table #(
  parameter int OPS  = 16,
  parameter int QW   = 6,
  parameter int TAGW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc,
  input  logic [QW-1:0]   alloc_q,
  output logic [TAGW-1:0] alloc_tag,
  output logic            full,
  input  logic            rel_req,
  input  logic [TAGW-1:0] rel_tag,
  output logic            rel_hit,
  output logic [QW-1:0]   rel_q
);
  localparam int IW = (OPS > 1) ? $clog2(OPS) : 1;

  logic [OPS-1:0] live;
  logic [QW-1:0]  owner [OPS];
  logic [IW-1:0]  free_idx, rel_idx;
  logic           rel_in_range;

  function automatic logic [IW-1:0] first_free(input logic [OPS-1:0] v);
    logic [IW-1:0] r = '0;
    for (int i = OPS - 1; i >= 0; i--) if (!v[i]) r = IW'(i);
    return r;
  endfunction

  assign free_idx     = first_free(live);
  assign full         = &live;
  assign alloc_tag    = TAGW'(free_idx);
  assign rel_idx      = rel_tag[IW-1:0];
  assign rel_in_range = (int'(rel_tag) < OPS);
  assign rel_hit      = rel_req && rel_in_range && live[rel_idx];
  assign rel_q        = owner[rel_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
    end else begin
      if (rel_hit) live[rel_idx] <= 1'b0;
      if (alloc)   live[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) owner[free_idx] <= alloc_q;
  end

  p_alloc_room_r7: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !full);
  p_release_frees_r8: assert property (@(posedge clk) disable iff (rst)
    rel_hit |=> !live[$past(rel_idx)]);
endmodule

// File: rtl/tq_axil_regs.sv
module tq_axil_regs
  import tq_pkg::*;
#(
  parameter int NQ = 64,
  parameter int QW = 6,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] awaddr,
  input  logic          awvalid,
  output logic          awready,
  input  logic [DW-1:0] wdata,
  input  logic [DW/8-1:0] wstrb,
  input  logic          wvalid,
  output logic          wready,
  output logic [1:0]    bresp,
  output logic          bvalid,
  input  logic          bready,
  input  logic [AW-1:0] araddr,
  input  logic          arvalid,
  output logic          arready,
  output logic [DW-1:0] rdata,
  output logic [1:0]    rresp,
  output logic          rvalid,
  input  logic          rready,
  input  logic          ctrl_valid,
  input  logic [QW-1:0] ctrl_queue,
  input  logic          ctrl_enable,
  output logic [NQ-1:0] q_en,
  output logic [NQ-1:0] q_act
);
  logic [AW-3:0] wr_idx, rd_idx;
  logic          wr_fire, wr_hit, rd_fire, rd_hit;
  logic          unused_bits;

  assign wr_idx  = awaddr[AW-1:2];
  assign rd_idx  = araddr[AW-1:2];
  assign wr_hit  = (int'(wr_idx) < NQ);
  assign rd_hit  = (int'(rd_idx) < NQ);
  assign awready = awvalid && wvalid && !bvalid;
  assign wready  = awready;
  assign wr_fire = awready;
  assign arready = !rvalid;
  assign rd_fire = arvalid && arready;
  assign bresp   = RESP_OKAY;
  assign rresp   = RESP_OKAY;
  assign unused_bits = ^{awaddr[1:0], araddr[1:0], wdata[DW-1:2], wstrb[DW/8-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      q_en   <= '0;
      q_act  <= '0;
      bvalid <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      if (bvalid && bready) bvalid <= 1'b0;
      if (wr_fire) begin
        bvalid <= 1'b1;
        if (wr_hit && wstrb[0]) begin
          q_en[wr_idx[QW-1:0]]  <= wdata[0];
          q_act[wr_idx[QW-1:0]] <= wdata[1];
        end
      end
      if (ctrl_valid) q_en[ctrl_queue] <= ctrl_enable;
      if (rvalid && rready) rvalid <= 1'b0;
      if (rd_fire) begin
        rvalid <= 1'b1;
        rdata  <= rd_hit ? DW'({q_act[rd_idx[QW-1:0]], q_en[rd_idx[QW-1:0]]}) : '0;
      end
    end
  end

  p_bresp_hold_r1: assert property (@(posedge clk) disable iff (rst)
    bvalid && !bready |=> bvalid);
  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (rst)
    rvalid && !rready |=> rvalid && $stable(rdata));
endmodule

// File: rtl/tq_rr_sched.sv
module tq_rr_sched
  import tq_pkg::*;
#(
  parameter int QW   = 6,
  parameter int TAGW = 8,
  parameter int LENW = 16,
  parameter int OPS  = 16,
  parameter int AW   = 16,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sched_en,
  input  logic            db_valid,
  input  logic [QW-1:0]   db_queue,
  output logic            db_ready,
  input  logic            ctrl_valid,
  input  logic [QW-1:0]   ctrl_queue,
  input  logic            ctrl_enable,
  output logic            ctrl_ready,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [QW-1:0]   req_queue,
  output logic [TAGW-1:0] req_tag,
  input  logic            sts_valid,
  output logic            sts_ready,
  input  logic [TAGW-1:0] sts_tag,
  input  logic [LENW-1:0] sts_len,
  input  logic [AW-1:0]   s_awaddr,
  input  logic            s_awvalid,
  output logic            s_awready,
  input  logic [DW-1:0]   s_wdata,
  input  logic [DW/8-1:0] s_wstrb,
  input  logic            s_wvalid,
  output logic            s_wready,
  output logic [1:0]      s_bresp,
  output logic            s_bvalid,
  input  logic            s_bready,
  input  logic [AW-1:0]   s_araddr,
  input  logic            s_arvalid,
  output logic            s_arready,
  output logic [DW-1:0]   s_rdata,
  output logic [1:0]      s_rresp,
  output logic            s_rvalid,
  input  logic            s_rready
);
  localparam int NQ = 1 << QW;

  logic [NQ-1:0] q_en, q_act, listed, busy, rearm;
  logic [QW-1:0] head, rel_q, push_q;
  logic          nonempty, ring_full, tbl_full, rel_hit;
  logic          head_ok, req_fire, drop_head, pop;
  logic          db_fire, db_ok, db_push, requeue, push;
  push_src_e     push_src;

  assign sts_ready  = 1'b1;
  assign ctrl_ready = 1'b1;
  assign db_ready   = !sts_valid;
  assign db_fire    = db_valid && db_ready;

  tq_axil_regs #(.NQ(NQ), .QW(QW), .AW(AW), .DW(DW)) i_regs (
    .clk(clk), .rst(rst),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .ctrl_valid(ctrl_valid), .ctrl_queue(ctrl_queue), .ctrl_enable(ctrl_enable),
    .q_en(q_en), .q_act(q_act)
  );

  tq_op_table #(.OPS(OPS), .QW(QW), .TAGW(TAGW)) i_table (
    .clk(clk), .rst(rst),
    .alloc(req_fire), .alloc_q(head), .alloc_tag(req_tag), .full(tbl_full),
    .rel_req(sts_valid), .rel_tag(sts_tag), .rel_hit(rel_hit), .rel_q(rel_q)
  );

  // head of the rotation: issue it when eligible, discard it when not
  assign head_ok   = queue_ok(q_en[head], q_act[head]);
  assign req_valid = nonempty && head_ok && sched_en && !tbl_full;
  assign req_queue = head;
  assign req_fire  = req_valid && req_ready;
  assign drop_head = nonempty && !head_ok;
  assign pop       = req_fire || drop_head;

  // at most one push per cycle: completion first, doorbell otherwise
  assign requeue  = keep_after_status(queue_ok(q_en[rel_q], q_act[rel_q]),
                                      sts_len != '0, rearm[rel_q]);
  assign db_ok    = db_fire && queue_ok(q_en[db_queue], q_act[db_queue]);
  assign db_push  = db_ok && !listed[db_queue] && !busy[db_queue];

  always_comb begin
    push_src = SRC_NONE;
    if (rel_hit && requeue) push_src = SRC_STATUS;
    else if (db_push)       push_src = SRC_DOORBELL;
  end

  assign push   = (push_src != SRC_NONE);
  assign push_q = (push_src == SRC_STATUS) ? rel_q : db_queue;

  tq_ring #(.W(QW), .DEPTH(NQ)) i_ring (
    .clk(clk), .rst(rst),
    .push(push), .push_data(push_q), .pop(pop),
    .head(head), .nonempty(nonempty), .full(ring_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      listed <= '0;
      busy   <= '0;
      rearm  <= '0;
    end else begin
      if (pop)      listed[head] <= 1'b0;
      if (req_fire) busy[head]   <= 1'b1;
      if (rel_hit) begin
        busy[rel_q]  <= 1'b0;
        rearm[rel_q] <= 1'b0;
        if (requeue) listed[rel_q] <= 1'b1;
      end
      if (db_ok) begin
        if (listed[db_queue] || busy[db_queue]) rearm[db_queue]  <= 1'b1;
        else                                    listed[db_queue] <= 1'b1;
      end
    end
  end

  p_req_gated_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> sched_en);
  p_req_eligible_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (q_en[req_queue] && q_act[req_queue]));
  p_db_yield_r11: assert property (@(posedge clk) disable iff (rst)
    sts_valid |-> !db_ready);
  p_no_dup_r6: assert property (@(posedge clk) disable iff (rst)
    push |-> !listed[push_q]);
  p_issue_marks_busy_r7: assert property (@(posedge clk) disable iff (rst)
    req_fire |=> busy[$past(req_queue)]);
  p_full_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    tbl_full |-> !req_valid);
endmodule

// File: tb/test_tq_rr_sched.sv
module test_tq_rr_sched;
  logic clk = 1'b0, rst = 1'b1, sched_en = 1'b0;
  logic db_valid = 1'b0, ctrl_valid = 1'b0, ctrl_enable = 1'b0;
  logic [5:0] db_queue = '0, ctrl_queue = '0;
  logic req_ready = 1'b0, sts_valid = 1'b0;
  logic [7:0] sts_tag = '0;
  logic [15:0] sts_len = '0;
  logic [15:0] awaddr = '0, araddr = '0;
  logic awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0] wstrb = 4'hF;
  logic db_ready, ctrl_ready, req_valid, sts_ready;
  logic [5:0] req_queue;
  logic [7:0] req_tag;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;

  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  tq_rr_sched i_tq_rr_sched (
    .clk(clk), .rst(rst), .sched_en(sched_en),
    .db_valid(db_valid), .db_queue(db_queue), .db_ready(db_ready),
    .ctrl_valid(ctrl_valid), .ctrl_queue(ctrl_queue), .ctrl_enable(ctrl_enable),
    .ctrl_ready(ctrl_ready),
    .req_valid(req_valid), .req_ready(req_ready), .req_queue(req_queue), .req_tag(req_tag),
    .sts_valid(sts_valid), .sts_ready(sts_ready), .sts_tag(sts_tag), .sts_len(sts_len),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(1'b1),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(1'b1)
  );

  task automatic chk(input string r, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic reg_wr(input int q_addr, input logic [31:0] d);
    awaddr = 16'(q_addr); wdata = d; awvalid = 1'b1; wvalid = 1'b1;
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    chk("R1 bvalid", int'(bvalid), 1);
    chk("R1 bresp", int'(bresp), 0);
    @(negedge clk);
  endtask

  task automatic reg_rd(input int q_addr, output int d);
    araddr = 16'(q_addr); arvalid = 1'b1;
    @(negedge clk);
    arvalid = 1'b0;
    d = (rvalid && rresp == 2'b00) ? int'(rdata) : -1;
    @(negedge clk);
  endtask

  task automatic ring(input int q);
    db_queue = 6'(q); db_valid = 1'b1;
    @(negedge clk);
    db_valid = 1'b0;
  endtask

  task automatic send_sts(input int t, input int len);
    sts_tag = 8'(t); sts_len = 16'(len); sts_valid = 1'b1;
    @(negedge clk);
    sts_valid = 1'b0;
  endtask

  task automatic get_req(output int q, output int t);
    int w = 0;
    #1;
    while (!req_valid && w < 100) begin @(negedge clk); #1; w++; end
    if (!req_valid) begin q = -1; t = -1; @(negedge clk); return; end
    q = int'(req_queue); t = int'(req_tag);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic no_req(input string r, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin #1; if (req_valid) seen = 1; @(negedge clk); end
    chk(r, seen, 0);
  endtask

  task automatic drain();
    int quiet = 0, q, t;
    while (quiet < 20) begin
      #1;
      if (req_valid) begin get_req(q, t); send_sts(t, 0); quiet = 0; end
      else begin @(negedge clk); quiet++; end
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int d, q, t;
    int tags[16];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values; R9 nothing issued after reset
    reg_rd(0, d);  chk("R1 reset read", d, 0);
    chk("R9 reset req_valid", int'(req_valid), 0);
    reg_wr(0, 32'd3); reg_rd(0, d); chk("R1 readback 3", d, 3);
    reg_wr(4, 32'hFFFF_FFFF); reg_rd(4, d); chk("R1 only two bits kept", d, 3);
    reg_wr(64 * 4, 32'd3); reg_rd(64 * 4, d); chk("R1 out of range reads 0", d, 0);

    // R4 / R5: ten queues in strict rotation
    for (int i = 0; i < 10; i++) reg_wr(i * 4, 32'd3);
    sched_en = 1'b1;
    for (int i = 0; i < 10; i++) ring(i);
    for (int k = 0; k < 30; k++) begin
      get_req(q, t);
      chk("R4 rotation order", q, k % 10);
      if (k == 0) chk("R7 first tag lowest", t, 0);
      send_sts(t, 1000);
    end
    for (int k = 0; k < 10; k++) begin
      get_req(q, t);
      chk("R5 nonzero requeue order", q, k);
      send_sts(t, 0);
    end
    no_req("R5 zero length retires", 30);

    // R7 / R8: fill the table
    for (int i = 10; i < 20; i++) reg_wr(i * 4, 32'd3);
    for (int i = 0; i < 20; i++) ring(i);
    for (int k = 0; k < 16; k++) begin
      get_req(q, t);
      tags[k] = t;
      chk("R7 tag sequence", t, k);
      chk("R4 fill order", q, k);
    end
    no_req("R7 table full blocks", 20);
    send_sts(200, 5);
    no_req("R8 unknown tag ignored", 10);
    send_sts(16, 5);
    no_req("R8 tag past table ignored", 10);
    send_sts(5, 0);
    get_req(q, t);
    chk("R7 freed slot queue", q, 16);
    chk("R7 freed slot reused", t, 5);
    for (int k = 0; k < 16; k++) if (k != 5) send_sts(tags[k], 0);
    send_sts(5, 0);
    drain();

    // R3 / R6: re-arm behaviour
    sched_en = 1'b0;
    ring(3); ring(3);
    sched_en = 1'b1;
    get_req(q, t); chk("R3 doorbell issues", q, 3);
    no_req("R6 no duplicate entry", 10);
    send_sts(t, 0);
    get_req(q, t); chk("R6 re-armed after zero length", q, 3);
    send_sts(t, 0);
    no_req("R6 re-arm used once", 20);
    ring(3);
    #1; chk("R3 request right after doorbell", int'(req_valid && req_queue == 6'd3), 1);
    get_req(q, t);
    ring(3);
    send_sts(t, 0);
    get_req(q, t); chk("R6 doorbell while in flight", q, 3);
    send_sts(t, 0);
    no_req("R5 idle after zero length", 10);

    // R9 global enable
    sched_en = 1'b0;
    ring(2);
    no_req("R9 disabled holds requests", 20);
    sched_en = 1'b1;
    #1; chk("R9 enable releases request", int'(req_valid && req_queue == 6'd2), 1);
    get_req(q, t); send_sts(t, 0);

    // R10 control stream / R2 ignored doorbell
    ctrl_queue = 6'd4; ctrl_enable = 1'b0; ctrl_valid = 1'b1;
    @(negedge clk); ctrl_valid = 1'b0;
    reg_rd(16, d); chk("R10 control clears enable", d, 2);
    ring(4);
    no_req("R2 doorbell to disabled queue", 20);
    ctrl_enable = 1'b1; ctrl_valid = 1'b1;
    @(negedge clk); ctrl_valid = 1'b0;
    reg_rd(16, d); chk("R10 control sets enable", d, 3);
    no_req("R2 ignored doorbell left no entry", 10);
    ring(4);
    get_req(q, t); chk("R10 enabled queue issues", q, 4);
    send_sts(t, 0);

    // R2 ineligible head is dropped
    sched_en = 1'b0;
    ring(6);
    reg_wr(24, 32'd1);
    sched_en = 1'b1;
    no_req("R2 inactive queue not issued", 10);
    reg_wr(24, 32'd3);
    no_req("R2 dropped entry gone", 10);
    ring(6);
    get_req(q, t); chk("R3 doorbell after drop", q, 6);
    send_sts(t, 0);

    // R11 status wins over doorbell
    chk("R11 status ready", int'(sts_ready), 1);
    chk("R11 control ready", int'(ctrl_ready), 1);
    sts_tag = 8'd99; sts_len = 16'd1; sts_valid = 1'b1;
    db_queue = 6'd7; db_valid = 1'b1;
    reg_wr(28, 32'd3);
    #1; chk("R11 doorbell stalled by status", int'(db_ready), 0);
    sts_valid = 1'b0;
    @(negedge clk);
    db_valid = 1'b0;
    get_req(q, t); chk("R11 doorbell accepted later", q, 7);
    send_sts(t, 0);
    no_req("R5 final idle", 10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule